// File: doc/BRIEF.md
# Privilege Trap and Return Sequencer

This block performs the atomic machine-control transfer between user and supervisor privilege. When the request is accepted while the privilege flag shows user mode, it pushes four words onto a supervisor stack: the stack pointer, the program counter, the status word and the instruction immediate. That stack starts from a separately held stack-top value. It then hands the CPU a new stack pointer and the supervisor entry address, and clears the user flag. When the request is accepted in supervisor mode, it pops the status word, then the program counter, then the stack pointer from the current stack.

The sequencer drives a single-port memory with one access per cycle. It asserts `busy` until the sequence has ended. In its last cycle it raises `done` together with one-cycle write strobes for the registers it changes. Everything the sequence needs is sampled in the cycle the request is accepted, so it runs to completion without interleaving. Instruction decode, address translation and the control-register contents belong to neighbouring blocks.

Top module: `priv_xfer_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. After that edge, `busy`, `done`, `mem_req`, `sp_wr`, `pc_wr`, `sw_wr` and `user_clr` are all low.
- R2: A request accepted with `user_mode`=1 gives four consecutive write cycles (`mem_req`=1, `mem_we`=1), starting in the cycle after acceptance. They go to addresses T, T-1, T-2 and T-3, where T is `stk_top`, and carry `sp_in`, `pc_in`, `sw_in` and `imm_in` in that order.
- R3: In the fifth cycle of a user-mode sequence, `done`=1 and `mem_req`=0. `sp_wr`=1 with `sp_out`=T-4, `pc_wr`=1 with `pc_out`=`entry_pc`, `user_clr`=1 and `sw_wr`=0.
- R4: A request accepted with `user_mode`=0 gives three consecutive read cycles (`mem_req`=1, `mem_we`=0) to addresses P+1, P+2 and P+3, where P is `sp_in`. Memory returns the read word on `mem_rdata` in the cycle after the request.
- R5: In the fourth cycle of a supervisor sequence, `done`=1 and `mem_req`=0. `sw_wr` carries the word read from P+1 on `sw_out`, `pc_wr` the word from P+2 on `pc_out`, and `sp_wr` the word from P+3 on `sp_out`. The loaded value replaces the incremented pointer. `user_clr`=0.
- R6: `busy` is high from the cycle after acceptance through the `done` cycle: 5 cycles for the push path and 4 for the pop path. It is low otherwise.
- R7: `start` is sampled only in idle cycles. A request held or raised while busy neither restarts nor alters the running sequence.
- R8: `user_mode`, `imm_in`, `sp_in`, `pc_in`, `sw_in`, `stk_top` and `entry_pc` are sampled at acceptance. Changes to them while busy have no effect on addresses, write data or results.
- R9: `done` lasts one cycle. `sp_wr`, `pc_wr`, `sw_wr` and `user_clr` are asserted only in the `done` cycle.
- R10: Address arithmetic wraps modulo 2^16 on both paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Transfer request, taken only when idle |
| user_mode | input | 1 | Current privilege flag (1 = user) |
| imm_in | input | 16 | Instruction immediate to push |
| sp_in | input | 16 | Current stack pointer (R6) |
| pc_in | input | 16 | Current program counter (R7) |
| sw_in | input | 16 | Current status word |
| stk_top | input | 16 | Supervisor stack top (CR2) |
| entry_pc | input | 16 | Supervisor entry address (CR0) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| sp_wr | output | 1 | Write strobe for stack pointer |
| sp_out | output | 16 | New stack pointer |
| pc_wr | output | 1 | Write strobe for program counter |
| pc_out | output | 16 | New program counter |
| sw_wr | output | 1 | Write strobe for status word |
| sw_out | output | 16 | New status word |
| user_clr | output | 1 | Clear the user-mode flag |

## Verification
Two events can fall in the same cycle: a new request arriving, and a sequence still running or just completing. The completion cycle also has to hand over the final loaded stack pointer at the same moment the memory read returns. To provoke the overlap, the bench keeps `start` high and scrambles every operand input, including the privilege flag, in every busy cycle of randomly chosen sequences. It judges the result by checking that addresses, write data, results and cycle counts still match the values latched at acceptance. It also checks that no second sequence begins before the following idle cycle.

// File: rtl/pxs_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the privilege transfer sequencer.
// Assumes the word counts of both paths fit in STEP_W bits.
package pxs_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PUSH = 2'd1,
        S_POP  = 2'd2,
        S_FIN  = 2'd3
    } seq_state_t;

    localparam int PUSH_WORDS = 4;
    localparam int POP_WORDS  = 3;
    localparam int STEP_W     = $clog2(PUSH_WORDS);
endpackage

// File: rtl/pxs_fsm.sv
`timescale 1ns/1ps
// Sequencing state machine: it accepts a request only in idle, chooses
// the push or pop path from the privilege flag, and counts the memory steps.
// Assumes start is a level that is sampled each idle cycle.
module pxs_fsm
    import pxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              user_mode,
    output seq_state_t        state,
    output logic [STEP_W-1:0] step,
    output logic              accept,
    output logic              push_mode
);
    localparam logic [STEP_W-1:0] PUSH_LAST = STEP_W'(PUSH_WORDS - 1);
    localparam logic [STEP_W-1:0] POP_LAST  = STEP_W'(POP_WORDS - 1);

    // Acceptance is possible only when no sequence is running.
    assign accept = (state == S_IDLE) && start;

    // State, step counter and path selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            step      <= '0;
            push_mode <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    step <= '0;
                    if (start) begin
                        push_mode <= user_mode;
                        state     <= user_mode ? S_PUSH : S_POP;
                    end
                end
                S_PUSH: begin
                    if (step == PUSH_LAST) begin
                        state <= S_FIN;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                S_POP: begin
                    if (step == POP_LAST) begin
                        state <= S_FIN;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R9: the completion state never repeats
    a_r9_fin_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FIN) |=> (state == S_IDLE));

    // R7: the path chosen at acceptance holds while busy
    a_r7_path_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(push_mode));

    // R6: a push step is always followed by another push step or completion
    a_r6_push_flow: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUSH) |=> (state == S_PUSH || state == S_FIN));
endmodule

// File: rtl/pxs_ptr.sv
`timescale 1ns/1ps
// Address pointer: it loads the stack top (push) or the stack pointer plus
// one (pop) at acceptance, then steps down or up once per memory cycle.
// Assumes arithmetic wraps modulo 2^W.
module pxs_ptr
    import pxs_pkg::*;
#(
    parameter int W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       user_mode,
    input  logic [W-1:0] stk_top,
    input  logic [W-1:0] sp_in,
    input  seq_state_t state,
    output logic [W-1:0] ptr
);
    // Pointer load and walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (accept) begin
            ptr <= user_mode ? stk_top : sp_in + 1'b1;
        end else if (state == S_PUSH) begin
            ptr <= ptr - 1'b1;
        end else if (state == S_POP) begin
            ptr <= ptr + 1'b1;
        end
    end

    // R2: push addresses descend by one per cycle
    a_r2_push_descend: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUSH) |=> (ptr == $past(ptr) - 1'b1));

    // R4: pop addresses ascend by one per cycle
    a_r4_pop_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_POP) |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/pxs_ctx.sv
`timescale 1ns/1ps
// Context holder: it latches the operands at acceptance, selects the push
// write data by step, and captures the popped status word and program counter.
// Assumes read data arrives the cycle after the read request.
module pxs_ctx
    import pxs_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  seq_state_t        state,
    input  logic [STEP_W-1:0] step,
    input  logic [W-1:0]      sp_in,
    input  logic [W-1:0]      pc_in,
    input  logic [W-1:0]      sw_in,
    input  logic [W-1:0]      imm_in,
    input  logic [W-1:0]      entry_pc,
    input  logic [W-1:0]      mem_rdata,
    output logic [W-1:0]      wdata,
    output logic [W-1:0]      entry_q,
    output logic [W-1:0]      pop_sw,
    output logic [W-1:0]      pop_pc
);
    logic [W-1:0] sp_q, pc_q, sw_q, imm_q;

    // Operand capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q    <= '0;
            pc_q    <= '0;
            sw_q    <= '0;
            imm_q   <= '0;
            entry_q <= '0;
        end else if (accept) begin
            sp_q    <= sp_in;
            pc_q    <= pc_in;
            sw_q    <= sw_in;
            imm_q   <= imm_in;
            entry_q <= entry_pc;
        end
    end

    // Capture of popped words; step s sees the data of read s-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_sw <= '0;
            pop_pc <= '0;
        end else if (state == S_POP) begin
            if (step == STEP_W'(1)) pop_sw <= mem_rdata;
            if (step == STEP_W'(2)) pop_pc <= mem_rdata;
        end
    end

    // Push order: stack pointer, program counter, status word, immediate.
    always_comb begin
        case (step)
            STEP_W'(0): wdata = sp_q;
            STEP_W'(1): wdata = pc_q;
            STEP_W'(2): wdata = sw_q;
            default:    wdata = imm_q;
        endcase
    end

    // R8: latched operands never move while a sequence runs
    a_r8_ctx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> ($stable(sp_q) && $stable(imm_q) && $stable(entry_q)));
endmodule

// File: rtl/priv_xfer_seq.sv
`timescale 1ns/1ps
// Privilege trap and return sequencer top: it joins the state machine,
// pointer and context holder, drives the memory port and produces the
// register updates in the completion cycle.
// Assumes a single-port memory with one-cycle read latency.
module priv_xfer_seq
    import pxs_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         user_mode,
    input  logic [W-1:0] imm_in,
    input  logic [W-1:0] sp_in,
    input  logic [W-1:0] pc_in,
    input  logic [W-1:0] sw_in,
    input  logic [W-1:0] stk_top,
    input  logic [W-1:0] entry_pc,
    output logic         busy,
    output logic         done,
    output logic         mem_req,
    output logic         mem_we,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    output logic         sp_wr,
    output logic [W-1:0] sp_out,
    output logic         pc_wr,
    output logic [W-1:0] pc_out,
    output logic         sw_wr,
    output logic [W-1:0] sw_out,
    output logic         user_clr
);
    seq_state_t        state;
    logic [STEP_W-1:0] step;
    logic              accept;
    logic              push_mode;
    logic [W-1:0]      ptr;
    logic [W-1:0]      wdata;
    logic [W-1:0]      entry_q;
    logic [W-1:0]      pop_sw;
    logic [W-1:0]      pop_pc;

    pxs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .user_mode (user_mode),
        .state     (state),
        .step      (step),
        .accept    (accept),
        .push_mode (push_mode)
    );

    pxs_ptr #(.W(W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .user_mode (user_mode),
        .stk_top   (stk_top),
        .sp_in     (sp_in),
        .state     (state),
        .ptr       (ptr)
    );

    pxs_ctx #(.W(W)) u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .state     (state),
        .step      (step),
        .sp_in     (sp_in),
        .pc_in     (pc_in),
        .sw_in     (sw_in),
        .imm_in    (imm_in),
        .entry_pc  (entry_pc),
        .mem_rdata (mem_rdata),
        .wdata     (wdata),
        .entry_q   (entry_q),
        .pop_sw    (pop_sw),
        .pop_pc    (pop_pc)
    );

    logic fin;
    assign fin = (state == S_FIN);

    // Memory port: one access per push or pop step.
    always_comb begin
        busy      = (state != S_IDLE);
        mem_req   = (state == S_PUSH) || (state == S_POP);
        mem_we    = (state == S_PUSH);
        mem_addr  = ptr;
        mem_wdata = wdata;
    end

    // Register updates in the completion cycle; the last popped word is the new stack pointer.
    always_comb begin
        done     = fin;
        sp_wr    = fin;
        pc_wr    = fin;
        sw_wr    = fin && !push_mode;
        user_clr = fin && push_mode;
        sp_out   = push_mode ? ptr : mem_rdata;
        pc_out   = push_mode ? entry_q : pop_pc;
        sw_out   = pop_sw;
    end

    // R1: a reset edge leaves the port quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        (!rst_n) |=> (!busy && !done && !mem_req && !sp_wr && !pc_wr && !sw_wr && !user_clr));

    // R9: completion lasts a single cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: register strobes only with completion
    a_r9_strobe_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_wr || pc_wr || sw_wr || user_clr) |-> done);

    // R3: leaving user mode always redirects the program counter and never touches the status word
    a_r3_user_exit: assert property (@(posedge clk) disable iff (!rst_n)
        user_clr |-> (pc_wr && sp_wr && !sw_wr && !mem_req));

    // R7: no new memory access starts in the cycle after completion
    a_r7_gap_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !mem_req);
endmodule

// File: tb/test_priv_xfer_seq.sv
`timescale 1ns/1ps
module test_priv_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        user_mode;
    logic [15:0] imm_in, sp_in, pc_in, sw_in, stk_top, entry_pc;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        sp_wr, pc_wr, sw_wr, user_clr;
    logic [15:0] sp_out, pc_out, sw_out;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] pend = 16'hDEAD;

    always #5 clk = ~clk;

    priv_xfer_seq i_priv_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .user_mode(user_mode),
        .imm_in(imm_in), .sp_in(sp_in), .pc_in(pc_in), .sw_in(sw_in),
        .stk_top(stk_top), .entry_pc(entry_pc), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sp_wr(sp_wr),
        .sp_out(sp_out), .pc_wr(pc_wr), .pc_out(pc_out), .sw_wr(sw_wr),
        .sw_out(sw_out), .user_clr(user_clr)
    );

    // Memory content model: word stored at an address.
    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic scramble();
        user_mode = 1'($urandom);
        imm_in    = 16'($urandom);
        sp_in     = 16'($urandom);
        pc_in     = 16'($urandom);
        sw_in     = 16'($urandom);
        stk_top   = 16'($urandom);
        entry_pc  = 16'($urandom);
    endtask

    // One complete sequence with per-cycle expected values.
    task automatic run_seq(input bit usr, input logic [15:0] r6, r7, sw, imm, top, ent,
                           input bit disturb);
        int last;
        logic [15:0] wexp [4];
        string t;
        wexp[0] = r6; wexp[1] = r7; wexp[2] = sw; wexp[3] = imm;
        last = usr ? 5 : 4;
        t = disturb ? (usr ? "R2/R7/R8" : "R4/R7/R8") : (usr ? "R2" : "R4");
        @(negedge clk);
        user_mode = usr; sp_in = r6; pc_in = r7; sw_in = sw;
        imm_in = imm; stk_top = top; entry_pc = ent; start = 1'b1;
        for (int k = 1; k <= last + 1; k++) begin
            @(negedge clk);
            mem_rdata = pend;
            #1;
            chk("R6", "busy", 16'(busy), 16'(k <= last));
            if (k < last) begin
                chk(t, "mem_req", 16'(mem_req), 16'd1);
                chk(t, "mem_we", 16'(mem_we), 16'(usr));
                if (usr) begin
                    chk(t, "push addr", mem_addr, top - 16'(k - 1));
                    chk(t, "push data", mem_wdata, wexp[k-1]);
                end else begin
                    chk(t, "pop addr", mem_addr, r6 + 16'(k));
                end
                chk("R9", "early done", 16'(done), 16'd0);
                chk("R9", "early strobes", 16'({sp_wr, pc_wr, sw_wr, user_clr}), 16'd0);
            end else if (k == last) begin
                chk(usr ? "R3" : "R5", "done", 16'(done), 16'd1);
                chk(usr ? "R3" : "R5", "mem_req at end", 16'(mem_req), 16'd0);
                chk(usr ? "R3" : "R5", "sp_wr", 16'(sp_wr), 16'd1);
                chk(usr ? "R3" : "R5", "pc_wr", 16'(pc_wr), 16'd1);
                chk(usr ? "R3" : "R5", "sw_wr", 16'(sw_wr), 16'(!usr));
                chk(usr ? "R3" : "R5", "user_clr", 16'(user_clr), 16'(usr));
                if (usr) begin
                    chk("R3", "sp_out", sp_out, top - 16'd4);
                    chk("R3", "pc_out", pc_out, ent);
                end else begin
                    chk("R5", "sw_out", sw_out, mem_word(r6 + 16'd1));
                    chk("R5", "pc_out", pc_out, mem_word(r6 + 16'd2));
                    chk("R5", "sp_out", sp_out, mem_word(r6 + 16'd3));
                end
            end else begin
                chk("R9", "done after end", 16'(done), 16'd0);
                chk("R7", "no restart", 16'(mem_req), 16'd0);
            end
            pend = (mem_req && !mem_we) ? mem_word(mem_addr) : 16'hDEAD;
            if (disturb && k < last) begin
                scramble();
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
    endtask

    initial begin
        #2000000;
        n_err++;
        $display("FAIL R6 watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b1; mem_rdata = 16'h0;
        scramble();
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "busy in reset", 16'(busy), 16'd0);
        chk("R1", "mem_req in reset", 16'(mem_req), 16'd0);
        chk("R1", "done in reset", 16'(done), 16'd0);
        chk("R1", "strobes in reset", 16'({sp_wr, pc_wr, sw_wr, user_clr}), 16'd0);
        start = 1'b0; rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1", "idle after reset", 16'({busy, mem_req, done}), 16'd0);

        // Directed: plain push, plain pop, wrapping addresses.
        run_seq(1'b1, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 16'h8000, 16'h0100, 1'b0);
        run_seq(1'b0, 16'h4000, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0);
        run_seq(1'b1, 16'hAAAA, 16'h5555, 16'h00FF, 16'hFF00, 16'h0002, 16'h0200, 1'b0); // R10
        run_seq(1'b0, 16'hFFFE, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0);                // R10
        run_seq(1'b1, 16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0000, 16'hFFFF, 1'b1); // R7 R8
        run_seq(1'b0, 16'hFFFF, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b1);                // R7 R8

        // Random mix, some with requests and operand changes during busy.
        for (int i = 0; i < 60; i++) begin
            run_seq(1'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                    16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule